// File: doc/BRIEF.md
# Row Latch Flash Write Controller

This block sits between a serial programming command decoder and a modelled flash array of 14-bit words. The decoder supplies the current word address, one strobe per operation, and a word stream for the write latches. The controller gathers up to 32 words in a row-wide latch bank, then commits them to the array on a programming strobe. It also runs bulk erase and row erase. Each timed operation runs for a fixed, parameterised number of clock cycles, except externally timed programming, which waits for an explicit end strobe.

The address space has two regions. Program space runs from 0000h to 1FFFh and aliases onto `PROG_WORDS` physical words. Configuration space is the row at 2000h. In that row, words 0 to 3 are user IDs, 4 and 5 are reserved, 6 is a fixed device identifier, 7 and 8 are configuration words, and 9 and 10 are calibration words. The address present on the edge where a strobe is accepted selects the target row and, for erases, the erase scope. The code-protect input guards program space only.

The latch stream is valid/ready. A word is taken on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is low for as long as `busy` is high. A source that sees `ld_ready` low must hold its word until it can be taken: a word presented while not ready is not stored.

Top module: `rowlatch_flash_ctl`

## Requirements
- R1: After reset, every program word, user ID, reserved word and configuration word reads 3FFFh; the device identifier reads `DEV_ID`; the two calibration words read `CAL1` and `CAL2`; `busy` is low and `ld_ready` is high.
- R2: A latch word is accepted when `ld_valid` and `ld_ready` are both high, into the latch numbered by address bits 4:0. A later load to the same latch number replaces the earlier word, so only the most recent word for each latch is committed.
- R3: A programming commit writes each loaded latch i to the word at {commit address bits 13:5, i}. Writes never leave that row: loads made at 0002h through 0021h and committed at 0021h land in 0020h through 003Fh. Positions whose latch was not loaded keep their contents. Programming does not erase first, so each written word becomes its old value AND the latched value.
- R4: An internally timed commit holds `busy` high for exactly `T_PROG` cycles in program space, or `T_CFG` cycles in the configuration row, starting on the edge that takes the strobe. The array changes on the edge where `busy` falls, and all latches are then empty.
- R5: An externally timed commit holds `busy` high until `end_ext` is sampled, and the array changes on that same edge. An `end_ext` pulse while no external commit is pending has no effect.
- R6: A commit in the configuration row changes only user IDs 0 to 3 and configuration words 7 and 8. An externally timed commit changes only the user IDs. The device identifier, the reserved words and the calibration words never change through a commit.
- R7: While `cp_on` is high, a commit strobe at a program-space address is ignored: `busy` stays low, the array is unchanged and the latches keep their words. Commits to the configuration row still proceed.
- R8: Row erase at a program-space address with `cp_on` low sets the 32-word row given by address bits 13:5 to 3FFFh, with `busy` high for `T_ROW` cycles. At 2000h through 2008h it sets only the four user IDs to 3FFFh, whatever `cp_on` is. At a program-space address with `cp_on` high, or at any configuration address above 2008h, it is ignored.
- R9: Bulk erase at 0000h through 1FFFh sets all program words and both configuration words to 3FFFh. At 2000h through 2008h it also clears the user IDs. Neither case depends on `cp_on`. It holds `busy` for `T_BULK` cycles and never changes the calibration words or the device identifier. Above 2008h it is ignored.
- R10: While `busy` is high, all start strobes are ignored and `ld_ready` is low, so no latch is loaded.
- R11: When several start strobes arrive in one cycle, only the highest-ranked one is considered: bulk erase, then row erase, then internal commit, then external commit. If that one is ignored, no operation starts.
- R12: A latch load accepted on the same edge as a commit strobe is part of that commit.
- R13: `rd_data` shows, without delay, the word at `rd_addr`. Program addresses below 2000h alias modulo `PROG_WORDS`. Addresses 2000h to 200Ah read the configuration row. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 14 | Current word address from the command decoder |
| cp_on | input | 1 | Code protection active for program space |
| ld_valid | input | 1 | Latch word valid |
| ld_ready | output | 1 | Latch word can be taken |
| ld_data | input | 14 | Latch word |
| start_int | input | 1 | Begin internally timed programming |
| start_ext | input | 1 | Begin externally timed programming |
| end_ext | input | 1 | End externally timed programming |
| start_bulk | input | 1 | Begin bulk erase |
| start_row | input | 1 | Begin row erase |
| busy | output | 1 | Timed operation in progress |
| rd_addr | input | 14 | Array read address |
| rd_data | output | 14 | Array read data |

## Verification
Two pairs of functions can meet in one cycle. The first is a latch load and a commit strobe: the bench raises `ld_valid` together with `start_int`, then reads the target word after `busy` falls. That word must hold the same-cycle data. The second is two start strobes together. The bench issues bulk erase with an internal commit at 2009h, where the erase is ignored and no commit may start. It then issues row erase with an internal commit in program space, which must run only the erase, for `T_ROW` cycles, and leave the latches intact for a later commit. Each result is judged by sweeping the whole read port against an arithmetic model of the array.

// File: rtl/flw_pkg.sv
package flw_pkg;
  localparam int AW   = 14;
  localparam int DW   = 14;
  localparam int LIDX = 5;
  localparam int NLAT = 32;
  localparam int NCFG = 11;

  localparam logic [8:0]    CFG_ROW = 9'h100;
  localparam logic [DW-1:0] BLANK   = 14'h3FFF;

  // configuration-row word positions (decoded by neighbours)
  localparam int ID_LAST  = 3;
  localparam int DEVID_IX = 6;
  localparam int CW1_IX   = 7;
  localparam int CW2_IX   = 8;
  localparam int CAL1_IX  = 9;
  localparam int CAL2_IX  = 10;

  typedef enum logic [2:0] {OP_IDLE, OP_PINT, OP_PEXT, OP_BULK, OP_ROW} op_e;

  function automatic logic in_prog(input logic [AW-1:0] a);
    return !a[13];
  endfunction

  function automatic logic in_user(input logic [AW-1:0] a);
    return (a[13:4] == 10'h200) && (a[3:0] <= 4'd8);
  endfunction

  function automatic logic cfg_wr_ok(input int ix, input logic ext);
    return (ix <= ID_LAST) || (!ext && (ix == CW1_IX || ix == CW2_IX));
  endfunction
endpackage

// File: rtl/flw_latches.sv
module flw_latches #(
  parameter int NL = 32,
  parameter int W  = 14,
  parameter int IW = $clog2(NL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [W-1:0]         wr_data,
  input  logic                 clr,
  output logic [NL-1:0][W-1:0] lat_data,
  output logic [NL-1:0]        lat_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_mask <= '0;
      lat_data <= '0;
    end else if (clr) begin
      lat_mask <= '0;
    end else if (wr_en) begin
      lat_mask[wr_idx] <= 1'b1;
      lat_data[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/flw_timer.sv
module flw_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  input  logic          ext,
  input  logic          end_req,
  output logic          busy,
  output logic          ext_wait,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = busy && (ext_wait ? end_req : (cnt == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ext_wait <= 1'b0;
      cnt      <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      ext_wait <= ext;
      cnt      <= len - CW'(1);
    end else if (done) begin
      busy     <= 1'b0;
      ext_wait <= 1'b0;
    end else if (busy && !ext_wait) begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/flw_array.sv
module flw_array import flw_pkg::*; #(
  parameter int            PROG_WORDS = 256,
  parameter int            PAW        = $clog2(PROG_WORDS),
  parameter logic [DW-1:0] DEV_ID     = 14'h2A41,
  parameter logic [DW-1:0] CAL1       = 14'h1234,
  parameter logic [DW-1:0] CAL2       = 14'h0567
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     apply,
  input  op_e                      op,
  input  logic [AW-1:0]            op_addr,
  input  logic [NLAT-1:0][DW-1:0]  lat_data,
  input  logic [NLAT-1:0]          lat_mask,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic [NCFG-1:0][DW-1:0]  cfg_q
);
  localparam int RW = PAW - LIDX;

  logic [DW-1:0] prog_q [PROG_WORDS];
  logic [RW-1:0] rsel;
  logic          tgt_prog;

  assign rsel     = op_addr[PAW-1:LIDX];
  assign tgt_prog = in_prog(op_addr);

  function automatic logic [DW-1:0] cfg_init(input int ix);
    case (ix)
      DEVID_IX: return DEV_ID;
      CAL1_IX:  return CAL1;
      CAL2_IX:  return CAL2;
      default:  return BLANK;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PROG_WORDS; i++) prog_q[i] <= BLANK;
      for (int j = 0; j < NCFG; j++) cfg_q[j] <= cfg_init(j);
    end else if (apply) begin
      case (op)
        OP_PINT, OP_PEXT: begin
          if (tgt_prog) begin
            for (int i = 0; i < NLAT; i++)
              if (lat_mask[i])
                prog_q[{rsel, LIDX'(i)}] <= prog_q[{rsel, LIDX'(i)}] & lat_data[i];
          end else begin
            for (int i = 0; i < NCFG; i++)
              if (lat_mask[i] && cfg_wr_ok(i, op == OP_PEXT))
                cfg_q[i] <= cfg_q[i] & lat_data[i];
          end
        end
        OP_ROW: begin
          if (tgt_prog) begin
            for (int i = 0; i < NLAT; i++) prog_q[{rsel, LIDX'(i)}] <= BLANK;
          end else begin
            for (int i = 0; i <= ID_LAST; i++) cfg_q[i] <= BLANK;
          end
        end
        OP_BULK: begin
          for (int i = 0; i < PROG_WORDS; i++) prog_q[i] <= BLANK;
          cfg_q[CW1_IX] <= BLANK;
          cfg_q[CW2_IX] <= BLANK;
          if (!tgt_prog)
            for (int i = 0; i <= ID_LAST; i++) cfg_q[i] <= BLANK;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (in_prog(rd_addr))
      rd_data = prog_q[rd_addr[PAW-1:0]];
    else if (rd_addr[13:4] == 10'h200 && rd_addr[3:0] <= 4'(CAL2_IX))
      rd_data = cfg_q[rd_addr[3:0]];
    else
      rd_data = '0;
  end
endmodule

// File: rtl/rowlatch_flash_ctl.sv
module rowlatch_flash_ctl import flw_pkg::*; #(
  parameter int            PROG_WORDS = 256,
  parameter int            T_PROG     = 2500,
  parameter int            T_CFG      = 5000,
  parameter int            T_BULK     = 5000,
  parameter int            T_ROW      = 2500,
  parameter logic [13:0]   DEV_ID     = 14'h2A41,
  parameter logic [13:0]   CAL1       = 14'h1234,
  parameter logic [13:0]   CAL2       = 14'h0567
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] addr,
  input  logic        cp_on,
  input  logic        ld_valid,
  output logic        ld_ready,
  input  logic [13:0] ld_data,
  input  logic        start_int,
  input  logic        start_ext,
  input  logic        end_ext,
  input  logic        start_bulk,
  input  logic        start_row,
  output logic        busy,
  input  logic [13:0] rd_addr,
  output logic [13:0] rd_data
);
  localparam int PAW  = $clog2(PROG_WORDS);
  localparam int TM_A = (T_PROG > T_CFG) ? T_PROG : T_CFG;
  localparam int TM_B = (T_BULK > T_ROW) ? T_BULK : T_ROW;
  localparam int TMAX = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int CW   = $clog2(TMAX + 1);

  op_e                     req_op, op_q;
  logic                    req_ok, go, done, ext_wait, lat_clr;
  logic [CW-1:0]           req_len;
  logic [AW-1:0]           op_addr_q;
  logic [NLAT-1:0][DW-1:0] lat_data;
  logic [NLAT-1:0]         lat_mask;
  logic [NCFG-1:0][DW-1:0] cfg_w;

  assign ld_ready = !busy;

  // fixed ranking among simultaneous strobes
  always_comb begin
    if (start_bulk)     req_op = OP_BULK;
    else if (start_row) req_op = OP_ROW;
    else if (start_int) req_op = OP_PINT;
    else if (start_ext) req_op = OP_PEXT;
    else                req_op = OP_IDLE;
  end

  always_comb begin
    req_ok  = 1'b0;
    req_len = CW'(1);
    case (req_op)
      OP_BULK: begin
        req_ok  = in_prog(addr) || in_user(addr);
        req_len = CW'(T_BULK);
      end
      OP_ROW: begin
        req_ok  = in_user(addr) || (in_prog(addr) && !cp_on);
        req_len = CW'(T_ROW);
      end
      OP_PINT, OP_PEXT: begin
        req_ok  = in_prog(addr) ? !cp_on : (addr[13:5] == CFG_ROW);
        req_len = in_prog(addr) ? CW'(T_PROG) : CW'(T_CFG);
      end
      default: ;
    endcase
  end

  assign go      = req_ok && !busy;
  assign lat_clr = done && (op_q == OP_PINT || op_q == OP_PEXT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q      <= OP_IDLE;
      op_addr_q <= '0;
    end else if (go) begin
      op_q      <= req_op;
      op_addr_q <= addr;
    end
  end

  flw_latches #(.NL(NLAT), .W(DW)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ld_valid && ld_ready),
    .wr_idx   (addr[LIDX-1:0]),
    .wr_data  (ld_data),
    .clr      (lat_clr),
    .lat_data (lat_data),
    .lat_mask (lat_mask)
  );

  flw_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (go),
    .len      (req_len),
    .ext      (req_op == OP_PEXT),
    .end_req  (end_ext),
    .busy     (busy),
    .ext_wait (ext_wait),
    .done     (done)
  );

  flw_array #(
    .PROG_WORDS (PROG_WORDS),
    .PAW        (PAW),
    .DEV_ID     (DEV_ID),
    .CAL1       (CAL1),
    .CAL2       (CAL2)
  ) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .apply    (done),
    .op       (op_q),
    .op_addr  (op_addr_q),
    .lat_data (lat_data),
    .lat_mask (lat_mask),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cfg_q    (cfg_w)
  );
endmodule

// File: rtl/rowlatch_flash_chk.sv
module rowlatch_flash_chk import flw_pkg::*; #(
  parameter logic [13:0] DEV_ID = 14'h2A41
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     ext_wait,
  input logic                     end_ext,
  input logic                     start_int,
  input logic                     start_row,
  input logic                     start_bulk,
  input logic                     cp_on,
  input logic [13:0]              addr,
  input logic [NCFG-1:0][DW-1:0]  cfg_w
);
  // R6: identifier word is never altered
  a_r6_devid_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_w[DEVID_IX] == DEV_ID);

  // R9: calibration words survive every operation
  a_r9_cal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_w[CAL1_IX]) && $stable(cfg_w[CAL2_IX]));

  // R5: end strobe during an external commit releases busy
  a_r5_end_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ext_wait && end_ext) |=> !busy);

  // R7: protected program-space commit never starts
  a_r7_cp_commit_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_int && !start_row && !start_bulk && cp_on && !addr[13]) |=> !busy);

  // R8: protected program-space row erase never starts
  a_r8_cp_row_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_row && !start_bulk && cp_on && !addr[13]) |=> !busy);

  // R11: an ignored top-ranked bulk erase blocks all lower strobes
  a_r11_bulk_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_bulk && addr > 14'h2008) |=> !busy);
endmodule

bind rowlatch_flash_ctl rowlatch_flash_chk #(.DEV_ID(DEV_ID)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .ext_wait   (ext_wait),
  .end_ext    (end_ext),
  .start_int  (start_int),
  .start_row  (start_row),
  .start_bulk (start_bulk),
  .cp_on      (cp_on),
  .addr       (addr),
  .cfg_w      (cfg_w)
);

// File: tb/sim_rowlatch_flash_ctl.sv
module sim_rowlatch_flash_ctl;
  localparam int PW = 256;
  localparam int TP = 8;
  localparam int TC = 16;
  localparam int TB = 20;
  localparam int TR = 6;
  localparam logic [13:0] DEVID = 14'h2A41;
  localparam logic [13:0] C1    = 14'h1234;
  localparam logic [13:0] C2    = 14'h0567;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cp_on, ld_valid, ld_ready, start_int, start_ext, end_ext;
  logic        start_bulk, start_row, busy;
  logic [13:0] addr, ld_data, rd_addr, rd_data;

  rowlatch_flash_ctl #(
    .PROG_WORDS(PW), .T_PROG(TP), .T_CFG(TC), .T_BULK(TB), .T_ROW(TR),
    .DEV_ID(DEVID), .CAL1(C1), .CAL2(C2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cp_on(cp_on),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .start_int(start_int), .start_ext(start_ext), .end_ext(end_ext),
    .start_bulk(start_bulk), .start_row(start_row), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  logic [13:0] pm [PW];
  logic [13:0] cm [11];
  logic [13:0] bl [32];
  bit          bm [32];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sweep(input string tag);
    int bad = 0;
    int fa = 0, fx = 0, fe = 0;
    for (int i = 0; i < PW; i++) begin
      rd_addr = 14'(i); #1;
      if (rd_data !== pm[i] && bad == 0) begin fa = i; fx = rd_data; fe = pm[i]; end
      if (rd_data !== pm[i]) bad++;
    end
    for (int j = 0; j < 11; j++) begin
      rd_addr = 14'h2000 + 14'(j); #1;
      if (rd_data !== cm[j] && bad == 0) begin fa = 'h2000 + j; fx = rd_data; fe = cm[j]; end
      if (rd_data !== cm[j]) bad++;
    end
    chk(bad == 0, $sformatf("%s sweep addr=%h", tag, fa), fx, fe);
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [13:0] a, input logic [13:0] e, input string tag);
    rd_addr = a; #1;
    chk(rd_data === e, tag, rd_data, e);
  endtask

  task automatic load(input logic [13:0] a, input logic [13:0] d, input bit acc);
    addr = a; ld_data = d; ld_valid = 1'b1; #1;
    chk(ld_ready === acc, "R2/R10 ld_ready", ld_ready, acc);
    @(negedge clk);
    ld_valid = 1'b0;
    if (acc) begin bl[a[4:0]] = d; bm[a[4:0]] = 1'b1; end
  endtask

  // kind bits: 0 int, 1 ext, 2 bulk, 3 row, 4 end
  task automatic strobe(input int kind, input logic [13:0] a);
    addr = a;
    start_int = kind[0]; start_ext = kind[1]; start_bulk = kind[2];
    start_row = kind[3]; end_ext = kind[4];
    @(negedge clk);
    start_int = 0; start_ext = 0; start_bulk = 0; start_row = 0; end_ext = 0;
  endtask

  task automatic wait_busy(input int exp, input string tag);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic m_commit(input logic [13:0] a, input bit ext);
    if (!a[13]) begin
      for (int i = 0; i < 32; i++)
        if (bm[i]) begin
          int t;
          t = ((int'(a) % PW) & ~31) + i;
          pm[t] = pm[t] & bl[i];
        end
    end else begin
      for (int i = 0; i < 11; i++)
        if (bm[i] && (i <= 3 || (!ext && (i == 7 || i == 8)))) cm[i] = cm[i] & bl[i];
    end
    for (int i = 0; i < 32; i++) bm[i] = 1'b0;
  endtask

  task automatic m_row(input logic [13:0] a);
    if (!a[13]) for (int i = 0; i < 32; i++) pm[((int'(a) % PW) & ~31) + i] = 14'h3FFF;
    else for (int i = 0; i < 4; i++) cm[i] = 14'h3FFF;
  endtask

  task automatic m_bulk(input logic [13:0] a);
    for (int i = 0; i < PW; i++) pm[i] = 14'h3FFF;
    cm[7] = 14'h3FFF; cm[8] = 14'h3FFF;
    if (a[13]) for (int i = 0; i < 4; i++) cm[i] = 14'h3FFF;
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cp_on = 0; ld_valid = 0; ld_data = 0; addr = 0; rd_addr = 0;
    start_int = 0; start_ext = 0; end_ext = 0; start_bulk = 0; start_row = 0;
    for (int i = 0; i < PW; i++) pm[i] = 14'h3FFF;
    for (int j = 0; j < 11; j++) cm[j] = 14'h3FFF;
    cm[6] = DEVID; cm[9] = C1; cm[10] = C2;
    for (int i = 0; i < 32; i++) begin bl[i] = 0; bm[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state, R13 read map
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(ld_ready === 1'b1, "R1 ld_ready", ld_ready, 1);
    sweep("R1");
    rd_chk(14'h3000, 14'h0000, "R13 unmapped");
    rd_chk(14'h2100, 14'h0000, "R13 beyond cfg row");
    @(negedge clk);

    // R2 R3 R4: span load 0002h..0021h, commit at 0021h
    for (int k = 0; k < 32; k++) load(14'(2 + k), 14'h1000 | 14'(k * 5), 1'b1);
    strobe(1, 14'h0021);
    m_commit(14'h0021, 0);
    wait_busy(TP, "R4 prog length");
    sweep("R3 row wrap");

    // R2 overwrite, R3 AND-programming
    load(14'h0045, 14'h1111, 1'b1);
    load(14'h0065, 14'h0F0F, 1'b1);
    strobe(1, 14'h0030);
    m_commit(14'h0030, 0);
    wait_busy(TP, "R4 prog length 2");
    rd_chk(14'h0025, pm[37], "R3 and-write");
    @(negedge clk);
    sweep("R2 overwrite");

    // R6 R4: configuration row, internal
    for (int k = 0; k < 11; k++) load(14'h2000 + 14'(k), 14'h0A50 ^ 14'(k * 3), 1'b1);
    strobe(1, 14'h2000);
    m_commit(14'h2000, 0);
    wait_busy(TC, "R4 cfg length");
    sweep("R6 cfg int");

    // R5 R6: external commit to configuration row
    load(14'h2001, 14'h0055, 1'b1);
    load(14'h2007, 14'h0101, 1'b1);
    strobe(2, 14'h2000);
    repeat (30) @(negedge clk);
    chk(busy === 1'b1, "R5 held", busy, 1);
    sweep("R5 pending");
    strobe(16, 14'h2000);
    m_commit(14'h2000, 1);
    chk(busy === 1'b0, "R5 release", busy, 0);
    sweep("R6 ext");

    // R5 external on program space, then stray end
    load(14'h0080, 14'h1234, 1'b1);
    strobe(2, 14'h0080);
    repeat (5) @(negedge clk);
    strobe(16, 14'h0080);
    m_commit(14'h0080, 0);
    chk(busy === 1'b0, "R5 prog release", busy, 0);
    strobe(16, 14'h0080);
    chk(busy === 1'b0, "R5 stray end", busy, 0);
    sweep("R5 prog");

    // R7 code protection
    cp_on = 1;
    load(14'h0090, 14'h0000, 1'b1);
    strobe(1, 14'h0090);
    chk(busy === 1'b0, "R7 refused", busy, 0);
    sweep("R7 prog kept");
    load(14'h2002, 14'h0333, 1'b1);
    strobe(1, 14'h2000);
    m_commit(14'h2000, 0);
    wait_busy(TC, "R7 cfg allowed");
    sweep("R7 cfg");

    // R8 row erase
    strobe(8, 14'h0025);
    chk(busy === 1'b0, "R8 cp ignored", busy, 0);
    strobe(8, 14'h2004);
    m_row(14'h2004);
    wait_busy(TR, "R8 id erase");
    sweep("R8 ids");
    cp_on = 0;
    strobe(8, 14'h2009);
    chk(busy === 1'b0, "R8 above 2008h ignored", busy, 0);
    strobe(8, 14'h0025);
    m_row(14'h0025);
    wait_busy(TR, "R8 row length");
    sweep("R8 row");

    // R10 strobes and loads during busy
    load(14'h0083, 14'h0007, 1'b1);
    strobe(8, 14'h0085);
    m_row(14'h0085);
    load(14'h0050, 14'h0000, 1'b0);
    strobe(4, 14'h0000);
    while (busy) @(negedge clk);
    strobe(1, 14'h0040);
    m_commit(14'h0040, 0);
    wait_busy(TP, "R10 commit after");
    sweep("R10 ignored");

    // R11 priority
    strobe(5, 14'h2009);
    chk(busy === 1'b0, "R11 bulk ranked above int", busy, 0);
    load(14'h0041, 14'h0001, 1'b1);
    strobe(9, 14'h0040);
    m_row(14'h0040);
    wait_busy(TR, "R11 row over int");
    sweep("R11 row only");
    strobe(1, 14'h0040);
    m_commit(14'h0040, 0);
    wait_busy(TP, "R11 latch kept");
    sweep("R11 later commit");

    // R12 load and commit together
    addr = 14'h0061; ld_data = 14'h2468; ld_valid = 1; start_int = 1;
    @(negedge clk);
    ld_valid = 0; start_int = 0;
    bl[1] = 14'h2468; bm[1] = 1;
    m_commit(14'h0061, 0);
    wait_busy(TP, "R12 length");
    rd_chk(14'h0061, 14'h2468, "R12 same-cycle load");
    @(negedge clk);

    // R9 bulk erase
    cp_on = 1;
    strobe(4, 14'h0000);
    m_bulk(14'h0000);
    wait_busy(TB, "R9 length");
    sweep("R9 prog scope");
    for (int k = 0; k < 4; k++) load(14'h2000 + 14'(k), 14'h0007, 1'b1);
    strobe(1, 14'h2000);
    m_commit(14'h2000, 0);
    wait_busy(TC, "R9 ids written");
    strobe(4, 14'h2003);
    m_bulk(14'h2003);
    wait_busy(TB, "R9 cfg length");
    sweep("R9 cfg scope");
    strobe(4, 14'h2009);
    chk(busy === 1'b0, "R9 above 2008h ignored", busy, 0);

    // R13 aliasing
    cp_on = 0;
    load(14'h1F45, 14'h0ABC, 1'b1);
    strobe(1, 14'h1F40);
    m_commit(14'h1F40, 0);
    wait_busy(TP, "R13 alias length");
    rd_chk(14'h0145, 14'h0ABC, "R13 alias read");
    @(negedge clk);
    sweep("R13 alias");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule